// File: doc/BRIEF.md
# Indexed Colour Palette with Sequential Byte Loading

This block is a 256-entry colour lookup table that the host fills through two byte-wide ports. The host first writes an entry number to the index port. It then writes three bytes to the shared data port, which carry the red, green and blue components in that order. The first two bytes are held in staging registers. When the blue byte arrives, the full 24-bit colour is written into the table in a single cycle, so the pixel side never sees a partly updated entry. After each completed triplet the index advances by one, which lets a host stream a run of consecutive entries after a single index write.

On the pixel side, a registered read port takes an 8-bit colour index and returns the stored colour one cycle later. Colours are packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. When the pixel path is not in 8-bit indexed mode, the table is skipped and the 24-bit input pixel is passed through with the same one-cycle delay. Reset loads every entry with a grey identity ramp.

Top module: `palette_seq_lut`

## Requirements
- R1: While rstN is low, pixOut is 0. After reset, entry i reads back as red = green = blue = i, that is {i,i,i}.
- R2: An index write followed by three data writes stores the bytes as red (bits 23:16), green (bits 15:8) and blue (bits 7:0) of the indexed entry.
- R3: An entry keeps its previous colour until the blue byte of a new triplet has been written.
- R4: A write to the index port returns the component phase to red and abandons any partial triplet. The abandoned entry is left unchanged.
- R5: After each completed triplet the index increases by one, wrapping from 255 to 0.
- R6: With pixIndexed high, pixOut shows the entry addressed by pixIn[7:0] at the first rising edge after pixIn is presented, and not before that edge.
- R7: If the blue byte for an entry and a pixel read of that same entry fall in the same cycle, the read returns the old colour. A read in the following cycle returns the new colour.
- R8: With pixIndexed low, pixOut equals pixIn one cycle later and the table is not used.
- R9: If idxWr and dataWr are both high in one cycle, the index write takes effect and the data byte is dropped.
- R10: Data and index writes made while rstN is low have no effect. After release, the index is 0 and the phase is red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idxWr | input | 1 | Strobe: hostByte is a new entry number |
| dataWr | input | 1 | Strobe: hostByte is the next colour component |
| hostByte | input | 8 | Host write data |
| pixIndexed | input | 1 | High selects 8-bit indexed lookup, low selects direct pass-through |
| pixIn | input | 24 | Pixel input; bits 7:0 are the index in indexed mode |
| pixOut | output | 24 | Registered colour output {red, green, blue} |

## Verification
The assertions assume that every input is a clean, synchronous level sampled at the rising clock edge, and that the host strobes are single-cycle pulses whose byte is valid in the same cycle. The bypass check also assumes that pixIndexed has been held for the cycle being compared. The bench changes every input only on the falling clock edge and reads pixOut on the next falling edge. Collisions, meaning an index write together with a data write, and a commit together with a read of the same entry, are driven on purpose within a single cycle, so those edge cases stay inside the synchronous assumptions.

// File: rtl/palPkg.sv
package palPkg;
  parameter int COMP_W  = 8;
  parameter int IDX_W   = 8;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PIX_W   = 3 * COMP_W;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phaseT;

  typedef struct packed {
    logic             capRed;
    logic             capGreen;
    logic             commit;
    logic [IDX_W-1:0] slot;
  } strobeT;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWr,
  input  logic              dataWr,
  input  logic [COMP_W-1:0] hostByte,
  output strobeT            strb
);
  logic [IDX_W-1:0] idxReg;
  phaseT            phase;
  logic             dataTake;

  // an index write in the same cycle drops the data byte (R9)
  assign dataTake = dataWr && !idxWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      phase  <= PH_RED;
    end else if (idxWr) begin
      idxReg <= IDX_W'(hostByte);
      phase  <= PH_RED;
    end else if (dataWr) begin
      case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase  <= PH_RED;
          idxReg <= idxReg + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strb.capRed   = dataTake && (phase == PH_RED);
    strb.capGreen = dataTake && (phase == PH_GREEN);
    strb.commit   = dataTake && (phase == PH_BLUE);
    strb.slot     = idxReg;
  end

  // R4: index write restarts at red
  a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (phase == PH_RED));

  // R5: a commit advances the index by one, wrapping
  a_r5_index_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (idxReg == IDX_W'($past(idxReg) + 1'b1)));

  // R5: otherwise the index moves only on an index write
  a_r5_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!idxWr && !strb.commit) |=> $stable(idxReg));
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [COMP_W-1:0] hostByte,
  input  logic              pixIndexed,
  input  logic [PIX_W-1:0]  pixIn,
  output logic [PIX_W-1:0]  pixOut
);
  logic [COMP_W-1:0] stageRed;
  logic [COMP_W-1:0] stageGreen;
  logic [PIX_W-1:0]  table_q [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageRed   <= '0;
      stageGreen <= '0;
    end else begin
      if (strb.capRed)   stageRed   <= hostByte;
      if (strb.capGreen) stageGreen <= hostByte;
    end
  end

  // whole triplet lands at once; identity ramp on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++)
        table_q[i] <= {3{COMP_W'(i)}};
    end else if (strb.commit) begin
      table_q[strb.slot] <= {stageRed, stageGreen, hostByte};
    end
  end

  // registered read: same-cycle commit is seen one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pixOut <= '0;
    else if (pixIndexed)
      pixOut <= table_q[pixIn[IDX_W-1:0]];
    else
      pixOut <= pixIn;
  end

  // R8: pass-through path in direct mode
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !pixIndexed |=> (pixOut == $past(pixIn)));
endmodule

// File: rtl/palette_seq_lut.sv
module palette_seq_lut
  import palPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWr,
  input  logic              dataWr,
  input  logic [COMP_W-1:0] hostByte,
  input  logic              pixIndexed,
  input  logic [PIX_W-1:0]  pixIn,
  output logic [PIX_W-1:0]  pixOut
);
  strobeT strb;

  palette_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .idxWr    (idxWr),
    .dataWr   (dataWr),
    .hostByte (hostByte),
    .strb     (strb)
  );

  palette_store u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostByte   (hostByte),
    .pixIndexed (pixIndexed),
    .pixIn      (pixIn),
    .pixOut     (pixOut)
  );
endmodule

// File: tb/palette_seq_lut_tb.sv
`timescale 1ns/1ps
module palette_seq_lut_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        idxWr = 1'b0;
  logic        dataWr = 1'b0;
  logic [7:0]  hostByte = 8'h0;
  logic        pixIndexed = 1'b1;
  logic [23:0] pixIn = 24'h0;
  logic [23:0] pixOut;
  int total = 0;
  int bad = 0;
  logic [23:0] got;

  always #2.5 clk = ~clk;

  palette_seq_lut u_dut (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .dataWr(dataWr),
    .hostByte(hostByte), .pixIndexed(pixIndexed), .pixIn(pixIn), .pixOut(pixOut)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic idxWrite(input logic [7:0] b);
    idxWr = 1'b1; hostByte = b;
    @(negedge clk);
    idxWr = 1'b0;
  endtask

  task automatic dataWrite(input logic [7:0] b);
    dataWr = 1'b1; hostByte = b;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] ix, output logic [23:0] v);
    pixIndexed = 1'b1; pixIn = {16'h0, ix};
    @(negedge clk);
    v = pixOut;
  endtask

  task automatic t_reset_ramp();
    check("R1 reset output", pixOut, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 256; i += 51) begin
      lookup(8'(i), got);
      check("R1 ramp", got, {3{8'(i)}});
    end
    lookup(8'd255, got);
    check("R1 ramp top", got, 24'hFFFFFF);
  endtask

  task automatic t_basic();
    idxWrite(8'd5);
    dataWrite(8'hAA); dataWrite(8'hBB); dataWrite(8'hCC);
    lookup(8'd5, got);
    check("R2 triplet order", got, 24'hAABBCC);
  endtask

  task automatic t_partial();
    idxWrite(8'd40);
    dataWrite(8'h11); dataWrite(8'h22);
    lookup(8'd40, got);
    check("R3 partial hidden", got, 24'h282828);
    dataWrite(8'h33);
    lookup(8'd40, got);
    check("R3 after blue", got, 24'h112233);
  endtask

  task automatic t_restart();
    idxWrite(8'd50);
    dataWrite(8'h77);
    idxWrite(8'd60);
    dataWrite(8'h01); dataWrite(8'h02); dataWrite(8'h03);
    lookup(8'd60, got);
    check("R4 restart at red", got, 24'h010203);
    lookup(8'd50, got);
    check("R4 abandoned entry", got, 24'h323232);
  endtask

  task automatic t_autoinc();
    idxWrite(8'd255);
    dataWrite(8'hA1); dataWrite(8'hA2); dataWrite(8'hA3);
    dataWrite(8'hB1); dataWrite(8'hB2); dataWrite(8'hB3);
    dataWrite(8'hC1); dataWrite(8'hC2); dataWrite(8'hC3);
    lookup(8'd255, got);
    check("R5 entry 255", got, 24'hA1A2A3);
    lookup(8'd0, got);
    check("R5 wrap to 0", got, 24'hB1B2B3);
    lookup(8'd1, got);
    check("R5 entry 1", got, 24'hC1C2C3);
  endtask

  task automatic t_latency();
    lookup(8'd7, got);
    check("R6 prior read", got, 24'h070707);
    pixIn = 24'h000008;
    #2;
    check("R6 not before edge", pixOut, 24'h070707);
    @(negedge clk);
    check("R6 after edge", pixOut, 24'h080808);
  endtask

  task automatic t_same_cycle();
    idxWrite(8'd100);
    dataWrite(8'h5A); dataWrite(8'h5B);
    dataWr = 1'b1; hostByte = 8'h5C; pixIndexed = 1'b1; pixIn = 24'h000064;
    @(negedge clk);
    dataWr = 1'b0;
    check("R7 same cycle old", pixOut, 24'h646464);
    @(negedge clk);
    check("R7 next cycle new", pixOut, 24'h5A5B5C);
  endtask

  task automatic t_bypass();
    pixIndexed = 1'b0; pixIn = 24'h123456;
    @(negedge clk);
    check("R8 bypass", pixOut, 24'h123456);
    pixIn = 24'hFEDC05;
    @(negedge clk);
    check("R8 bypass high bits", pixOut, 24'hFEDC05);
    pixIndexed = 1'b1;
  endtask

  task automatic t_collide();
    idxWrite(8'd10);
    idxWr = 1'b1; dataWr = 1'b1; hostByte = 8'd20;
    @(negedge clk);
    idxWr = 1'b0; dataWr = 1'b0;
    dataWrite(8'hD1); dataWrite(8'hD2); dataWrite(8'hD3);
    lookup(8'd20, got);
    check("R9 index wins", got, 24'hD1D2D3);
    lookup(8'd10, got);
    check("R9 old index untouched", got, 24'h0A0A0A);
  endtask

  task automatic t_reset_writes();
    rstN = 1'b0;
    dataWrite(8'h99);
    idxWrite(8'd33);
    dataWrite(8'h98);
    check("R1 output in reset", pixOut, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    dataWrite(8'hE1); dataWrite(8'hE2); dataWrite(8'hE3);
    lookup(8'd0, got);
    check("R10 writes in reset ignored", got, 24'hE1E2E3);
    lookup(8'd33, got);
    check("R10 entry 33 ramp", got, 24'h212121);
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_ramp();
    t_basic();
    t_partial();
    t_restart();
    t_autoinc();
    t_latency();
    t_same_cycle();
    t_bypass();
    t_collide();
    t_reset_writes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule